// File: doc/BRIEF.md
# Edge-Triggered Manual Reset Pulse Timer

This block turns a push-button style manual reset request into a reset pulse of fixed length for a supervisor. The request input can be configured as active-high or active-low. After a two-flop synchronizer, only the transition into the active level is used. That transition starts a counter of `TIMEOUT_CYCLES` system clocks, and a complementary pair of reset outputs stays asserted for the whole count. Holding the button longer does not lengthen the pulse.

A separate memory-disable output serves a companion memory interface. It is asserted while the reset pulse runs, and also for as long as the synchronized request stays at its active level. A memory therefore ignores all accesses while the button is held, even after the reset pulse has ended. The default timeout is 10,000,000 cycles, which is 200 ms at 50 MHz. A testbench overrides it with a short value.

Top module: `mr_pulse_timer`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1, `rst_out_n` is 0 and `mem_disable` is 1.
- R2: With `ACTIVE_HIGH`=1 a rising edge of `mr_in` starts a pulse. With `ACTIVE_HIGH`=0 a falling edge starts it. Both configurations give identical outputs when driven with mutually inverted inputs.
- R3: `mr_in` passes through two flops. `mem_disable` follows an input activation after the 2nd rising clock edge. `rst_out` rises after the 3rd rising clock edge.
- R4: An isolated activation holds `rst_out` high for exactly `TIMEOUT_CYCLES` clock cycles.
- R5: If the input stays active longer than `TIMEOUT_CYCLES`, `rst_out` still drops when the count ends.
- R6: The inactive edge and a steady active level never start or extend a pulse.
- R7: A new activation during a running pulse restarts the count, so `rst_out` stays high for `TIMEOUT_CYCLES` cycles counted from the restart.
- R8: `rst_out_n` is always the exact complement of `rst_out`.
- R9: `mem_disable` is 1 whenever `rst_out` is 1 or the synchronized input is active. It drops 2 clock edges after the input is released if no pulse is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mr_in | input | 1 | Manual reset request, polarity set by `ACTIVE_HIGH` |
| rst_out | output | 1 | Reset pulse, active high |
| rst_out_n | output | 1 | Reset pulse, active low |
| mem_disable | output | 1 | Blocks companion memory accesses while high |

## Verification
Four press shapes are applied:
- A short tap that ends well before the timeout. It separates a pulse measured from the edge from one that follows the button.
- A hold far longer than the timeout. It shows that the reset outputs drop on time while the memory disable lingers until release.
- A second tap landing inside a running pulse. It tells restart-from-zero apart from an ignored retrigger or an extended count.
- Idle gaps and release edges. They confirm that only the active edge starts anything.

An active-low instance driven with the inverted stimulus must track the active-high instance cycle for cycle.

// File: rtl/mr_pulse_timer.sv
module mr_pulse_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 10_000_000,
  parameter bit          ACTIVE_HIGH    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_in,
  output logic rst_out,
  output logic rst_out_n,
  output logic mem_disable
);
  localparam int unsigned CW   = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);
  localparam logic IDLE_LVL    = ACTIVE_HIGH ? 1'b0 : 1'b1;

  logic [1:0]    sync_q;
  logic          act_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          act_lvl;
  logic          edge_hit;

  assign act_lvl  = ACTIVE_HIGH ? sync_q[1] : ~sync_q[1];
  assign edge_hit = act_lvl & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{IDLE_LVL}};
      act_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], mr_in};
      act_q  <= act_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (edge_hit) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_out     = ~rst_n | busy_q;
  assign rst_out_n   = ~rst_out;
  assign mem_disable = rst_out | act_lvl;
endmodule

module mr_pulse_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_out,
  input logic rst_out_n,
  input logic mem_disable
);
  p_reset_state_r1: assert property (@(posedge clk) !rst_n |-> (rst_out && !rst_out_n && mem_disable));
  p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n) rst_out != rst_out_n);
  p_mem_covers_reset_r9: assert property (@(posedge clk) disable iff (!rst_n) rst_out |-> mem_disable);
  p_start_needs_level_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_out) |-> $past(mem_disable));
endmodule

bind mr_pulse_timer mr_pulse_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_out(rst_out), .rst_out_n(rst_out_n), .mem_disable(mem_disable)
);

// File: tb/mr_pulse_timer_tb.sv
module mr_pulse_timer_tb;
  localparam int unsigned T = 12;

  typedef struct {
    bit    rst;
    bit    mem;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mr = 1'b0;
  logic mr_lo;
  logic r_hi, rn_hi, m_hi, r_lo, rn_lo, m_lo;
  int   n_tests = 0;
  int   n_fail = 0;
  item_t q[$];
  bit   h1 = 0, h2 = 0, h3 = 0;
  int   rem = 0;

  assign mr_lo = ~mr;
  always #10 clk = ~clk;

  mr_pulse_timer #(.TIMEOUT_CYCLES(T), .ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .mr_in(mr), .rst_out(r_hi), .rst_out_n(rn_hi), .mem_disable(m_hi));
  mr_pulse_timer #(.TIMEOUT_CYCLES(T), .ACTIVE_HIGH(1'b0)) u_dut_lo (
    .clk(clk), .rst_n(rst_n), .mr_in(mr_lo), .rst_out(r_lo), .rst_out_n(rn_lo), .mem_disable(m_lo));

  task automatic chk(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one input level per cycle and predicts the outputs after the next edge.
  task automatic tick(bit v, string tag);
    item_t it;
    @(negedge clk);
    mr = v;
    if (h2 && !h3) rem = T;
    else if (rem > 0) rem--;
    h3 = h2; h2 = h1; h1 = v;
    it.rst = (rem > 0);
    it.mem = it.rst | h2;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic hold(bit v, int n, string tag);
    for (int i = 0; i < n; i++) tick(v, tag);
  endtask

  // Monitor: pops one prediction per clock and compares both instances.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk({it.tag, " rst_out"}, r_hi, it.rst);
        chk({it.tag, " mem_disable"}, m_hi, it.mem);
        chk({it.tag, " R8 rst_out_n"}, rn_hi, ~it.rst);
        chk({it.tag, " R2 low-polarity rst_out"}, r_lo, it.rst);
        chk({it.tag, " R2 low-polarity mem_disable"}, m_lo, it.mem);
        chk({it.tag, " R8 low-polarity rst_out_n"}, rn_lo, ~it.rst);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 rst_out in reset", r_hi, 1'b1);
      chk("R1 rst_out_n in reset", rn_hi, 1'b0);
      chk("R1 mem_disable in reset", m_hi, 1'b1);
      chk("R1 low-polarity rst_out in reset", r_lo, 1'b1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    hold(1'b0, 5, "R6 idle");
    hold(1'b1, 3, "R3 R4 short tap");
    hold(1'b0, 20, "R4 R6 tap release");
    hold(1'b1, 3 * T, "R5 R9 long hold");
    hold(1'b0, 10, "R9 R6 long release");
    hold(1'b1, 2, "R7 first tap");
    hold(1'b0, 5, "R7 gap");
    hold(1'b1, 2, "R7 retrigger");
    hold(1'b0, 2 * T + 4, "R7 R4 after retrigger");
    hold(1'b1, 1, "R3 one-cycle tap");
    hold(1'b0, T + 6, "R4 one-cycle tap tail");
    while (q.size() > 0) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule